// File: doc/BRIEF.md
# Speculative Load Ordering Checker

This block tracks loads that were allowed to run ahead of older stores whose addresses were still unknown. Loads take a slot in program order, and a load's slot is filled in when it executes: its physical address, whether it ran ahead of an unresolved store, and which store supplied its data if it was forwarded. Slots are freed strictly from the oldest end when loads retire.

When a store commits, it presents its physical address, its store tag and a snapshot of the allocation pointer that was taken when the store was dispatched. Every slot at or after that snapshot holds a younger load. The block searches those slots for executed, speculative loads at the same address whose data did not come from this store. If it finds any, it raises a one-cycle replay request that names the oldest such load. That load is reset to unexecuted, and every slot younger than it is discarded, so the front end can re-fetch from there.

The queue depth must be a power of two. The store's pointer snapshot must lie within one queue depth of the oldest live slot. A snapshot that points at or before the oldest slot means every live load is younger than the store.

Top module: `ldq_violation_detector`

## Requirements
- R1: After reset, `alloc_ready` is 1, `replay_valid` is 0 and `alloc_ptr` is 0.
- R2: Each accepted allocation returns the current `alloc_ptr` (lower bits are the slot index, the top bit is a wrap bit) and advances it by one. `alloc_ready` is 0 while DEPTH loads are held.
- R3: `retire_valid` frees the oldest held load. A full queue accepts an allocation again after one retirement, and retirement does not move `alloc_ptr`.
- R4: A store commit that finds no conflicting load leaves `replay_valid` at 0 on the next cycle, and the queue keeps its contents.
- R5: An executed, speculative load that is younger than the committing store (slot at or after `commit_lq_ptr`) and has an equal address is a conflict. The cycle after the commit, `replay_valid` is 1 for one cycle and `replay_idx` is its slot.
- R6: A load forwarded from the committing store (`exec_fwd`=1 with `exec_fwd_sid` equal to `commit_sid`) is not a conflict. A load forwarded from a different store is a conflict.
- R7: The commit check ignores loads that have not executed and loads older than the store's snapshot.
- R8: When several loads conflict, `replay_idx` names the oldest one. All younger loads are discarded, so `alloc_ptr` becomes that load's pointer plus one.
- R9: The replayed load returns to unexecuted, so a later commit to the same address does not flag it again until it executes again.
- R10: Addresses are compared on all bits. A store to 0x800A conflicts with a load to 0x800A, but not with loads to 0x400C or 0x800B.
- R11: A load that executed without running ahead of any unresolved store (`exec_spec`=0) is ignored by the commit check.
- R12: In a cycle whose commit raises a replay, `alloc_ready` is 0, and allocation and retirement requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate the next load slot |
| alloc_ready | output | 1 | Slot available and no replay this cycle |
| alloc_ptr | output | $clog2(DEPTH)+1 | Pointer given to the load being allocated |
| exec_valid | input | 1 | A held load has executed |
| exec_idx | input | $clog2(DEPTH) | Slot of the executed load |
| exec_addr | input | AW | Physical address of the load |
| exec_spec | input | 1 | Load ran ahead of an unresolved older store |
| exec_fwd | input | 1 | Load data was forwarded from a store |
| exec_fwd_sid | input | SIDW | Tag of the forwarding store |
| commit_valid | input | 1 | A store commits this cycle |
| commit_addr | input | AW | Physical address of the store |
| commit_sid | input | SIDW | Tag of the committing store |
| commit_lq_ptr | input | $clog2(DEPTH)+1 | Allocation pointer snapshot taken at store dispatch |
| retire_valid | input | 1 | Oldest load retires |
| replay_valid | output | 1 | Replay request, one cycle |
| replay_idx | output | $clog2(DEPTH) | Slot of the oldest conflicting load |

## Verification
A slot whose executed or speculative flag is wrong shows up on the next store commit to its address. The replay either fails to appear or appears with the wrong slot one cycle after that commit. A wrong age or oldest-first decision shows up in `replay_idx`. A flush that goes too far or not far enough shows up at once in `alloc_ptr`, and later in how many allocations fit before `alloc_ready` drops. The sweep tries every pattern of conflicting slots against every store position in a full queue. After each replay, it commits the same store again to confirm that the replayed load was reset to unexecuted.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    // Per-slot status bits
    typedef struct packed {
        logic done;   // load has executed
        logic spec;   // load ran ahead of an unresolved store
        logic fwd;    // data came from a store
    } ldq_flags_t;

    localparam ldq_flags_t LDQ_FLAGS_CLEAR = '0;

endpackage

// File: rtl/ldq_entry_match.sv
module ldq_entry_match
    import ldq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int SIDW = 4
) (
    input  logic            live,
    input  logic            younger,
    input  ldq_flags_t      flags,
    input  logic [AW-1:0]   ld_addr,
    input  logic [SIDW-1:0] ld_sid,
    input  logic [AW-1:0]   st_addr,
    input  logic [SIDW-1:0] st_sid,
    output logic            hit
);
    logic same_src;

    always_comb begin
        same_src = flags.fwd && (ld_sid == st_sid);
        hit = live && younger && flags.done && flags.spec &&
              (ld_addr == st_addr) && !same_src;
    end
endmodule

// File: rtl/ldq_oldest_sel.sv
module ldq_oldest_sel #(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hit,
    input  logic [PW-1:0]    base,
    output logic             found,
    output logic [PW-1:0]    idx,
    output logic [PW-1:0]    age
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        age   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!found && hit[base + PW'(k)]) begin
                found = 1'b1;
                idx   = base + PW'(k);
                age   = PW'(k);
            end
        end
    end
endmodule

// File: rtl/ldq_violation_detector.sv
module ldq_violation_detector
    import ldq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int SIDW  = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    output logic            alloc_ready,
    output logic [PW:0]     alloc_ptr,
    input  logic            exec_valid,
    input  logic [PW-1:0]   exec_idx,
    input  logic [AW-1:0]   exec_addr,
    input  logic            exec_spec,
    input  logic            exec_fwd,
    input  logic [SIDW-1:0] exec_fwd_sid,
    input  logic            commit_valid,
    input  logic [AW-1:0]   commit_addr,
    input  logic [SIDW-1:0] commit_sid,
    input  logic [PW:0]     commit_lq_ptr,
    input  logic            retire_valid,
    output logic            replay_valid,
    output logic [PW-1:0]   replay_idx
);
    localparam logic [PW:0] DEPTH_W = (PW+1)'(DEPTH);

    typedef struct packed {
        logic [PW:0]                       head;
        logic [PW:0]                       tail;
        logic [DEPTH-1:0][AW-1:0]          addr;
        logic [DEPTH-1:0][SIDW-1:0]        sid;
        ldq_flags_t [DEPTH-1:0]            flg;
        logic                              rp_vld;
        logic [PW-1:0]                     rp_idx;
    } state_t;

    state_t s_q, s_d;

    logic [PW:0]      occ_w;
    logic [PW:0]      dist_w;
    logic [PW:0]      bound_w;
    logic [DEPTH-1:0] live_w;
    logic [DEPTH-1:0] hit_w;
    logic             found_w;
    logic [PW-1:0]    sel_idx_w;
    logic [PW-1:0]    sel_age_w;
    logic             viol_w;

    always_comb begin
        occ_w   = s_q.tail - s_q.head;
        dist_w  = commit_lq_ptr - s_q.head;
        // snapshot at or before the oldest slot: everything is younger
        bound_w = (dist_w > DEPTH_W) ? '0 : dist_w;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PW-1:0] age_w;
        logic          younger_w;
        always_comb begin
            age_w     = PW'(i) - s_q.head[PW-1:0];
            live_w[i] = {1'b0, age_w} < occ_w;
            younger_w = {1'b0, age_w} >= bound_w;
        end
        ldq_entry_match #(.AW(AW), .SIDW(SIDW)) u_match (
            .live    (live_w[i]),
            .younger (younger_w),
            .flags   (s_q.flg[i]),
            .ld_addr (s_q.addr[i]),
            .ld_sid  (s_q.sid[i]),
            .st_addr (commit_addr),
            .st_sid  (commit_sid),
            .hit     (hit_w[i])
        );
    end

    ldq_oldest_sel #(.DEPTH(DEPTH)) u_sel (
        .hit   (hit_w),
        .base  (s_q.head[PW-1:0]),
        .found (found_w),
        .idx   (sel_idx_w),
        .age   (sel_age_w)
    );

    assign viol_w       = commit_valid && found_w;
    assign alloc_ready  = (occ_w != DEPTH_W) && !viol_w;
    assign alloc_ptr    = s_q.tail;
    assign replay_valid = s_q.rp_vld;
    assign replay_idx   = s_q.rp_idx;

    always_comb begin
        s_d        = s_q;
        s_d.rp_vld = 1'b0;

        if (exec_valid && live_w[exec_idx]) begin
            s_d.addr[exec_idx] = exec_addr;
            s_d.sid[exec_idx]  = exec_fwd_sid;
            s_d.flg[exec_idx]  = '{done: 1'b1, spec: exec_spec, fwd: exec_fwd};
        end

        if (viol_w) begin
            s_d.rp_vld         = 1'b1;
            s_d.rp_idx         = sel_idx_w;
            s_d.flg[sel_idx_w] = LDQ_FLAGS_CLEAR;
            s_d.tail           = s_q.head + {1'b0, sel_age_w} + 1'b1;
        end else begin
            if (alloc_valid && alloc_ready) begin
                s_d.flg[s_q.tail[PW-1:0]] = LDQ_FLAGS_CLEAR;
                s_d.tail                  = s_q.tail + 1'b1;
            end
            if (retire_valid && (occ_w != '0)) begin
                s_d.head = s_q.head + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ldq_violation_checker.sv
module ldq_violation_checker #(
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic [PW:0]   alloc_ptr,
    input logic          commit_valid,
    input logic          replay_valid,
    input logic [PW-1:0] replay_idx
);
    // R2: accepted allocation advances the pointer by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && alloc_ready |=> alloc_ptr == (PW+1)'($past(alloc_ptr) + 1'b1));

    // R2: without allocation or commit the pointer holds
    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_valid && alloc_ready) && !commit_valid |=> $stable(alloc_ptr));

    // R5: replay only follows a store commit
    a_r5_replay_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_valid |=> !replay_valid);

    // R8: younger slots flushed, pointer right after the replayed load
    a_r8_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> alloc_ptr[PW-1:0] == PW'(replay_idx + 1'b1));

    // R12: no allocation accepted in a cycle that triggers replay
    a_r12_replay_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |-> $past(!alloc_ready || !alloc_valid));
endmodule

bind ldq_violation_detector ldq_violation_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .alloc_ptr    (alloc_ptr),
    .commit_valid (commit_valid),
    .replay_valid (replay_valid),
    .replay_idx   (replay_idx)
);

// File: tb/ldq_violation_detector_tb.sv
module ldq_violation_detector_tb;
    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int SIDW  = 4;
    localparam int PW    = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            alloc_valid = 1'b0;
    logic            alloc_ready;
    logic [PW:0]     alloc_ptr;
    logic            exec_valid = 1'b0;
    logic [PW-1:0]   exec_idx = '0;
    logic [AW-1:0]   exec_addr = '0;
    logic            exec_spec = 1'b0;
    logic            exec_fwd = 1'b0;
    logic [SIDW-1:0] exec_fwd_sid = '0;
    logic            commit_valid = 1'b0;
    logic [AW-1:0]   commit_addr = '0;
    logic [SIDW-1:0] commit_sid = '0;
    logic [PW:0]     commit_lq_ptr = '0;
    logic            retire_valid = 1'b0;
    logic            replay_valid;
    logic [PW-1:0]   replay_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ldq_violation_detector #(.DEPTH(DEPTH), .AW(AW), .SIDW(SIDW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic do_alloc(input int n);
        for (int k = 0; k < n; k++) begin
            alloc_valid = 1'b1;
            tick();
            alloc_valid = 1'b0;
        end
    endtask

    task automatic do_exec(input int idx, input int addr, input bit spec,
                           input bit fwd, input int sid);
        exec_valid   = 1'b1;
        exec_idx     = PW'(idx);
        exec_addr    = AW'(addr);
        exec_spec    = spec;
        exec_fwd     = fwd;
        exec_fwd_sid = SIDW'(sid);
        tick();
        exec_valid   = 1'b0;
    endtask

    task automatic do_commit(input int addr, input int sid, input int ptr);
        commit_valid  = 1'b1;
        commit_addr   = AW'(addr);
        commit_sid    = SIDW'(sid);
        commit_lq_ptr = (PW+1)'(ptr);
        tick();
        commit_valid  = 1'b0;
    endtask

    initial begin
        int exp_k;
        do_reset();
        // R1
        chk(alloc_ready == 1'b1, "R1 ready", int'(alloc_ready), 1);
        chk(replay_valid == 1'b0, "R1 replay", int'(replay_valid), 0);
        chk(alloc_ptr == '0, "R1 ptr", int'(alloc_ptr), 0);

        // Sweep: every conflict pattern against every store position (R2 R5 R7 R8 R9)
        for (int b = 0; b < DEPTH; b++) begin
            for (int p = 0; p < (1 << DEPTH); p++) begin
                do_reset();
                do_alloc(DEPTH);
                chk(alloc_ready == 1'b0, "R2 full", int'(alloc_ready), 0);
                chk(alloc_ptr == (PW+1)'(DEPTH), "R2 ptr", int'(alloc_ptr), DEPTH);
                for (int e = 0; e < DEPTH; e++)
                    do_exec(e, p[e] ? 'h800A : 'h400C, 1'b1, 1'b0, 0);
                exp_k = -1;
                for (int e = DEPTH - 1; e >= b; e--)
                    if (p[e]) exp_k = e;
                do_commit('h800A, 3, b);
                if (exp_k < 0) begin
                    chk(replay_valid == 1'b0, "R4/R7 none", int'(replay_valid), 0);
                    chk(alloc_ptr == (PW+1)'(DEPTH), "R4 kept", int'(alloc_ptr), DEPTH);
                end else begin
                    chk(replay_valid == 1'b1, "R5 replay", int'(replay_valid), 1);
                    chk(int'(replay_idx) == exp_k, "R8 oldest", int'(replay_idx), exp_k);
                    chk(int'(alloc_ptr) == exp_k + 1, "R8 flush", int'(alloc_ptr), exp_k + 1);
                    tick();
                    chk(replay_valid == 1'b0, "R5 one cycle", int'(replay_valid), 0);
                    do_commit('h800A, 3, exp_k);
                    chk(replay_valid == 1'b0, "R9 reset", int'(replay_valid), 0);
                end
            end
        end

        // R6: forwarded from this store vs from another
        do_reset();
        do_alloc(2);
        do_exec(1, 'h800A, 1'b1, 1'b1, 5);
        do_commit('h800A, 5, 0);
        chk(replay_valid == 1'b0, "R6 same store", int'(replay_valid), 0);
        do_commit('h800A, 6, 0);
        chk(replay_valid == 1'b1 && replay_idx == 1, "R6 other store", int'(replay_idx), 1);

        // R11: non-speculative load ignored
        do_reset();
        do_alloc(2);
        do_exec(0, 'h800A, 1'b0, 1'b0, 0);
        do_commit('h800A, 1, 0);
        chk(replay_valid == 1'b0, "R11 nonspec", int'(replay_valid), 0);

        // R10: full address compare
        do_reset();
        do_alloc(3);
        do_exec(0, 'h800B, 1'b1, 1'b0, 0);
        do_exec(1, 'h400C, 1'b1, 1'b0, 0);
        do_commit('h800A, 1, 0);
        chk(replay_valid == 1'b0, "R10 differ", int'(replay_valid), 0);
        do_exec(2, 'h800A, 1'b1, 1'b0, 0);
        do_commit('h800A, 1, 0);
        chk(replay_valid == 1'b1 && replay_idx == 2, "R10 equal", int'(replay_idx), 2);

        // R7: unexecuted loads ignored
        do_reset();
        do_alloc(2);
        do_commit('h800A, 1, 0);
        chk(replay_valid == 1'b0, "R7 unexecuted", int'(replay_valid), 0);

        // R3: retirement frees the oldest slot
        do_reset();
        do_alloc(DEPTH);
        chk(alloc_ready == 1'b0, "R3 full", int'(alloc_ready), 0);
        retire_valid = 1'b1;
        tick();
        retire_valid = 1'b0;
        chk(alloc_ready == 1'b1, "R3 freed", int'(alloc_ready), 1);
        chk(alloc_ptr == (PW+1)'(DEPTH), "R3 ptr held", int'(alloc_ptr), DEPTH);
        do_alloc(1);
        chk(alloc_ptr == (PW+1)'(DEPTH + 1), "R3 wrap", int'(alloc_ptr), DEPTH + 1);

        // R12: allocation and retirement ignored in a replay cycle
        do_reset();
        do_alloc(4);
        do_exec(2, 'h1234, 1'b1, 1'b0, 0);
        commit_valid  = 1'b1;
        commit_addr   = AW'('h1234);
        commit_sid    = '0;
        commit_lq_ptr = '0;
        alloc_valid   = 1'b1;
        retire_valid  = 1'b1;
        #1;
        chk(alloc_ready == 1'b0, "R12 not ready", int'(alloc_ready), 0);
        tick();
        commit_valid = 1'b0;
        alloc_valid  = 1'b0;
        retire_valid = 1'b0;
        chk(alloc_ptr == 3, "R12 ptr", int'(alloc_ptr), 3);
        do_alloc(DEPTH - 3);
        chk(alloc_ready == 1'b0, "R12 retire ignored", int'(alloc_ready), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule